// File: doc/BRIEF.md
# Inbound Address Window Translator

This block models one inbound memory window of a bridge between an external bus and an internal bus. Three registers set up the window. A limit register sets the window size, and it also acts as a per-bit write mask on the base address register. The base address register places the window in the external address space. A translation value register selects where claimed addresses land on the internal side. Bit 0 of the limit register is a claim-disable flag. When it is set, the window stays sized but claims nothing.

A bus agent presents an external address with a valid strobe. The block compares the address bits above the 4 KiB page against the base, using only the bits that the limit enables. The hit flag and the translated internal address come out registered, one cycle later. Inside the window, the upper address bits come from the translation value. The offset bits pass through unchanged.

Top module: `inwin_translator`

## Requirements
- R1: After reset, the limit, base and translation registers all read 0, and the hit output is 0.
- R2: The limit register is at offset 0x58. Bits 31:12 and bit 0 read back as written. Bits 11:1 always read 0.
- R3: The base register is at offset 0x18. A write updates only the bits whose limit bit (31:12) is 1. Reads return 0 in every bit whose current limit bit is 0, and in bits 11:0.
- R4: While the limit register is all zeros, a base write has no effect, and the base still reads 0 afterwards.
- R5: One cycle after a valid address, the hit output is 1 when that address equals the base in every bit of 31:12 that the limit enables.
- R6: While limit bit 0 (claim disable) is 1, the hit output stays 0 even for a matching address. Clearing the bit restores claiming.
- R7: While limit bits 31:12 are all zero, no address ever hits.
- R8: One cycle after a valid address, the translated output equals (translation AND limit) OR (address AND NOT limit) in bits 31:12, with bits 11:0 copied from the address. Translation bits outside the limit are ignored.
- R9: The hit output is 1 only in the cycle after the valid input was 1. Without valid, the hit output is 0.
- R10: A read from any offset other than 0x18, 0x58 or 0x5C returns 0. A write to such an offset changes no register.
- R11: The translation register is at offset 0x5C. Bits 31:12 read back as written, and bits 11:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regOffset | input | 8 | Register offset for reads and writes |
| regWrData | input | 32 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdData | output | 32 | Combinational read data for regOffset |
| addrValid | input | 1 | External address valid |
| addrIn | input | 32 | External bus address |
| hitOut | output | 1 | Window claims the previous valid address |
| xlatAddr | output | 32 | Internal address for the previous valid address |

## Verification
Two conditions are hard to reach from the ports. The first is a window that is fully sized but told not to claim. The second is a base register whose value is partly fixed at zero by a limit set after the base was written. The stimulus builds the first by writing the same full mask twice: once with bit 0 set and once with it clear, repeating the lookup between the two writes. For the second, it writes a sparse limit, writes all ones to the base, and reads it back. The vector table also uses a translation value that is not aligned to the window, so the ignored bits are visible at the translated output.

// File: rtl/inwin_pkg.sv
package inwin_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LIMIT,
    SEL_BASE,
    SEL_XLAT
  } rdSel_e;

  typedef struct packed {
    logic wrLimit;
    logic wrBase;
    logic wrXlat;
    logic look;
  } strobes_t;
endpackage

// File: rtl/inwin_ctrl.sv
module inwin_ctrl
  import inwin_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] LIMIT_OFF = 8'h58,
  parameter logic [OFF_W-1:0] BASE_OFF  = 8'h18,
  parameter logic [OFF_W-1:0] XLAT_OFF  = 8'h5C
) (
  input  logic [OFF_W-1:0] regOffset,
  input  logic             regWrEn,
  input  logic             addrValid,
  output strobes_t         strobes,
  output rdSel_e           rdSel
);
  always_comb begin
    rdSel = SEL_NONE;
    if (regOffset == LIMIT_OFF)      rdSel = SEL_LIMIT;
    else if (regOffset == BASE_OFF)  rdSel = SEL_BASE;
    else if (regOffset == XLAT_OFF)  rdSel = SEL_XLAT;
  end

  always_comb begin
    strobes.wrLimit = regWrEn && (rdSel == SEL_LIMIT);
    strobes.wrBase  = regWrEn && (rdSel == SEL_BASE);
    strobes.wrXlat  = regWrEn && (rdSel == SEL_XLAT);
    strobes.look    = addrValid;
  end
endmodule

// File: rtl/inwin_datapath.sv
module inwin_datapath
  import inwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  localparam int UP_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  rdSel_e            rdSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] rdData,
  output logic              hitOut,
  output logic [ADDR_W-1:0] xlatAddr,
  output logic [UP_W-1:0]   limitHi,
  output logic [UP_W-1:0]   baseHi,
  output logic              claimOff
);
  logic [UP_W-1:0]   xlatHi;
  logic [UP_W-1:0]   addrHi;
  logic              matchHi;
  logic              hitNext;
  logic [ADDR_W-1:0] xlatNext;
  logic              unusedLowBits;

  assign addrHi        = addrIn[ADDR_W-1:PAGE_W];
  assign unusedLowBits = ^wrData[PAGE_W-1:1];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitHi  <= '0;
      claimOff <= 1'b0;
      baseHi   <= '0;
      xlatHi   <= '0;
    end else begin
      if (strobes.wrLimit) begin
        limitHi  <= wrData[ADDR_W-1:PAGE_W];
        claimOff <= wrData[0];
      end
      if (strobes.wrBase) begin
        baseHi <= wrData[ADDR_W-1:PAGE_W] & limitHi;
      end
      if (strobes.wrXlat) begin
        xlatHi <= wrData[ADDR_W-1:PAGE_W];
      end
    end
  end

  // Window compare and translation
  always_comb begin
    matchHi  = ((addrHi ^ baseHi) & limitHi) == '0;
    hitNext  = strobes.look && !claimOff && (|limitHi) && matchHi;
    xlatNext = {(xlatHi & limitHi) | (addrHi & ~limitHi), addrIn[PAGE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitOut   <= 1'b0;
      xlatAddr <= '0;
    end else begin
      hitOut <= hitNext;
      if (strobes.look) xlatAddr <= xlatNext;
    end
  end

  // Read mux
  always_comb begin
    case (rdSel)
      SEL_LIMIT: rdData = {limitHi, {(PAGE_W-1){1'b0}}, claimOff};
      SEL_BASE:  rdData = {baseHi & limitHi, {PAGE_W{1'b0}}};
      SEL_XLAT:  rdData = {xlatHi, {PAGE_W{1'b0}}};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/inwin_translator.sv
module inwin_translator
  import inwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int OFF_W  = 8,
  parameter logic [OFF_W-1:0] LIMIT_OFF = 8'h58,
  parameter logic [OFF_W-1:0] BASE_OFF  = 8'h18,
  parameter logic [OFF_W-1:0] XLAT_OFF  = 8'h5C,
  localparam int UP_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFF_W-1:0]  regOffset,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              hitOut,
  output logic [ADDR_W-1:0] xlatAddr
);
  strobes_t        strobes;
  rdSel_e          rdSel;
  logic [UP_W-1:0] limitHi;
  logic [UP_W-1:0] baseHi;
  logic            claimOff;

  inwin_ctrl #(
    .OFF_W(OFF_W), .LIMIT_OFF(LIMIT_OFF), .BASE_OFF(BASE_OFF), .XLAT_OFF(XLAT_OFF)
  ) u_ctrl (
    .regOffset(regOffset),
    .regWrEn  (regWrEn),
    .addrValid(addrValid),
    .strobes  (strobes),
    .rdSel    (rdSel)
  );

  inwin_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .addrIn  (addrIn),
    .rdData  (regRdData),
    .hitOut  (hitOut),
    .xlatAddr(xlatAddr),
    .limitHi (limitHi),
    .baseHi  (baseHi),
    .claimOff(claimOff)
  );
endmodule

// File: rtl/inwin_checker.sv
module inwin_checker #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int OFF_W  = 8,
  parameter logic [OFF_W-1:0] BASE_OFF = 8'h18,
  localparam int UP_W = ADDR_W - PAGE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [OFF_W-1:0]  regOffset,
  input logic [ADDR_W-1:0] regRdData,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrIn,
  input logic              hitOut,
  input logic [ADDR_W-1:0] xlatAddr,
  input logic [UP_W-1:0]   limitHi,
  input logic [UP_W-1:0]   baseHi,
  input logic              claimOff
);
  // R9
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> $past(addrValid));

  // R6
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> !$past(claimOff));

  // R7
  zero_limit_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> ($past(limitHi) != '0));

  // R5
  hit_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> ((($past(addrIn[ADDR_W-1:PAGE_W]) ^ $past(baseHi)) & $past(limitHi)) == '0));

  // R8
  low_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrValid) |-> (xlatAddr[PAGE_W-1:0] == $past(addrIn[PAGE_W-1:0])));

  // R3
  base_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regOffset == BASE_OFF) |->
      ((regRdData[PAGE_W-1:0] == '0) && ((regRdData[ADDR_W-1:PAGE_W] & ~limitHi) == '0)));
endmodule

bind inwin_translator inwin_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .BASE_OFF(BASE_OFF)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regOffset(regOffset),
  .regRdData(regRdData),
  .addrValid(addrValid),
  .addrIn   (addrIn),
  .hitOut   (hitOut),
  .xlatAddr (xlatAddr),
  .limitHi  (limitHi),
  .baseHi   (baseHi),
  .claimOff (claimOff)
);

// File: tb/sim_inwin_translator.sv
module sim_inwin_translator;
  localparam logic [7:0] OFF_LIMIT = 8'h58;
  localparam logic [7:0] OFF_BASE  = 8'h18;
  localparam logic [7:0] OFF_XLAT  = 8'h5C;

  typedef struct packed {
    logic [31:0] lim;
    logic [31:0] base;
    logic [31:0] xlat;
    logic [31:0] addr;
    logic [31:0] expBase;
    logic        expHit;
    logic [31:0] expX;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'hFFFF0000, 32'h80000000, 32'h12340000, 32'h8000ABCD, 32'h80000000, 1'b1, 32'h1234ABCD},
    '{32'hFFFF0000, 32'h80000000, 32'h12340000, 32'h8001ABCD, 32'h80000000, 1'b0, 32'h1234ABCD},
    '{32'hFFF00000, 32'h8ABCDEF0, 32'h40000000, 32'h8ABFFFFF, 32'h8AB00000, 1'b1, 32'h400FFFFF},
    '{32'hFFFFF000, 32'hC0001000, 32'h00002000, 32'hC0001FFF, 32'hC0001000, 1'b1, 32'h00002FFF},
    '{32'hFFFFF000, 32'hC0001000, 32'h00002000, 32'hC0002000, 32'hC0001000, 1'b0, 32'h00002000},
    '{32'hFFFF0001, 32'h80000000, 32'h12340000, 32'h80001234, 32'h80000000, 1'b0, 32'h12341234},
    '{32'h00000000, 32'h80000000, 32'h12340000, 32'h00000010, 32'h00000000, 1'b0, 32'h00000010},
    '{32'h80000000, 32'hFFFFFFFF, 32'h56789000, 32'h87654321, 32'h80000000, 1'b1, 32'h07654321}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regOffset = '0;
  logic [31:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regRdData;
  logic        addrValid = 1'b0;
  logic [31:0] addrIn = '0;
  logic        hitOut;
  logic [31:0] xlatAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  inwin_translator u0 (
    .clk(clk), .rstN(rstN), .regOffset(regOffset), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .addrValid(addrValid),
    .addrIn(addrIn), .hitOut(hitOut), .xlatAddr(xlatAddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] off, input logic [31:0] data);
    @(negedge clk);
    regOffset = off; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regReadChk(input logic [7:0] off, input logic [31:0] exp, input string tag);
    regOffset = off;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    addrIn = a; addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regReadChk(OFF_LIMIT, 32'h0, "R1 limit");
    regReadChk(OFF_BASE,  32'h0, "R1 base");
    regReadChk(OFF_XLAT,  32'h0, "R1 xlat");
    check("R1 hit", {31'b0, hitOut}, 32'h0);

    // Vector table: R5 R8 R3 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      regWrite(OFF_LIMIT, VECS[i].lim);
      regWrite(OFF_BASE,  VECS[i].base);
      regWrite(OFF_XLAT,  VECS[i].xlat);
      regReadChk(OFF_BASE, VECS[i].expBase, $sformatf("R3 base vec%0d", i));
      lookup(VECS[i].addr);
      check($sformatf("R5 hit vec%0d", i), {31'b0, hitOut}, {31'b0, VECS[i].expHit});
      check($sformatf("R8 xlat vec%0d", i), xlatAddr, VECS[i].expX);
    end

    // R2 limit readback with reserved bits
    regWrite(OFF_LIMIT, 32'hFFFF0FFF);
    regReadChk(OFF_LIMIT, 32'hFFFF0001, "R2 limit");

    // R11 translation readback
    regWrite(OFF_XLAT, 32'h12345678);
    regReadChk(OFF_XLAT, 32'h12345000, "R11 xlat");

    // R4 zero limit blocks base writes
    regWrite(OFF_LIMIT, 32'h0);
    regWrite(OFF_BASE, 32'hFFFFFFFF);
    regReadChk(OFF_BASE, 32'h0, "R4 base");
    // R7 zero limit: address equal to zero base does not hit
    lookup(32'h00000000);
    check("R7 hit", {31'b0, hitOut}, 32'h0);

    // R3 sparse limit set after base: bits outside limit read 0
    regWrite(OFF_LIMIT, 32'hF0F0F000);
    regWrite(OFF_BASE, 32'hFFFFFFFF);
    regReadChk(OFF_BASE, 32'hF0F0F000, "R3 sparse base");
    regWrite(OFF_LIMIT, 32'hF0000000);
    regReadChk(OFF_BASE, 32'hF0000000, "R3 shrunk limit");

    // R6 disable then re-enable claiming of the same window
    regWrite(OFF_LIMIT, 32'hFFFF0001);
    regWrite(OFF_BASE, 32'hA0000000);
    lookup(32'hA0000100);
    check("R6 disabled", {31'b0, hitOut}, 32'h0);
    regWrite(OFF_LIMIT, 32'hFFFF0000);
    lookup(32'hA0000100);
    check("R6 re-enabled", {31'b0, hitOut}, 32'h1);

    // R9 hit drops without valid
    addrIn = 32'hA0000100;
    @(negedge clk);
    check("R9 no valid", {31'b0, hitOut}, 32'h0);

    // R10 unknown offset
    regWrite(8'h20, 32'hDEADBEEF);
    regReadChk(8'h20, 32'h0, "R10 unknown read");
    regReadChk(OFF_LIMIT, 32'hFFFF0000, "R10 limit intact");
    regReadChk(OFF_BASE, 32'hA0000000, "R10 base intact");
    regReadChk(OFF_XLAT, 32'h12345000, "R10 xlat intact");

    finish();
  end
endmodule